// File: doc/BRIEF.md
# Quad double-buffered DAC register controller

This block sits behind a serial receiver and interprets each complete 16-bit command word for a four-channel, 12-bit converter. Every channel has two stages of storage: a staging (input) register and a live (DAC) register whose value drives the converter. Commands can fill one staging register quietly, fill one and then transfer all four, transfer all four on their own, or write one code into every register at once.

The same command space sets a general-purpose logic output, picks the serial-out edge mode and puts the converter into a low-power shutdown. A lockout pin can veto shutdown. Pulling the lockout pin low while shut down wakes the converter at once, without waiting for a clock. Shutdown keeps every register value and only forces the channel output enables off. Any later command that writes the live registers ends shutdown.

Top module: `quad_dac_regctl`

## Requirements
- R1: A word is {addr[1:0], ctl[1:0], data[11:0]} from bit 15 down. With cmd_valid high and ctl=01, data goes into the staging register that addr selects (0=channel A … 3=channel D). No live code changes.
- R2: With ctl=11, data goes into the selected staging register. In the same clock all four live registers take their staging values, and the selected channel takes the new data.
- R3: Code {addr,ctl}=0100 copies every staging register into its live register.
- R4: Code 1000 writes data into all four staging registers and all four live registers.
- R5: Code 1100 enters shutdown only when pdl_n is high. While shutdown is high, out_en is all zero and the live codes keep their values. With pdl_n low, code 1100 has no effect.
- R6: Code 0010 drives upo low and code 0110 drives upo high.
- R7: Code 1110 sets dout_mode to 1 and code 1010 sets it to 0. Both also copy every staging register into its live register.
- R8: Code 0000 changes no output.
- R9: Any command that writes the live registers (R2, R3, R4, R7) clears shutdown on the same clock edge that updates the codes.
- R10: While pdl_n is low, shutdown reads low and out_en reads all ones, without waiting for a clock. The codes are the ones held before shutdown.
- R11: clr_n low at a clock edge zeroes all staging and live registers, drives upo low, sets dout_mode to 0 and clears shutdown. It overrides any command in that cycle.
- R12: While rst_n is low, all codes are zero, upo is low, dout_mode is 0, shutdown is low and out_en is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_n | input | 1 | Active-low clear, sampled on the clock |
| pdl_n | input | 1 | Active-low shutdown lockout; low vetoes and exits shutdown |
| cmd_valid | input | 1 | Strobe marking cmd_word as a complete command |
| cmd_word | input | 16 | Command word {addr, ctl, data} |
| dac_codes | output | 48 | Live codes, channel i at bits [12*i+11:12*i] |
| out_en | output | 4 | Per-channel output enable, low while shut down |
| shutdown | output | 1 | Shutdown flag |
| upo | output | 1 | User logic output level |
| dout_mode | output | 1 | Serial-out edge mode, 0 falling, 1 rising |

## Verification
On every cycle the assertions check these properties: a staging-only load leaves the live codes untouched; a broadcast or load-and-update places the written data where it belongs; a no-op, the lockout veto and a clear act as specified; and every live-register write ends shutdown. Staging registers cannot be observed directly. Their contents show only when a later transfer exposes them. Whether a load reached the right staging slot is therefore shown only by the bench's command sequences and its step-by-step model. That also covers a code held across shutdown and recalled afterwards, and the asynchronous wake from the lockout pin.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  localparam int ADDR_W = 2;
  localparam int CTRL_W = 2;
  localparam int N_CH   = 1 << ADDR_W;

  typedef enum logic [CTRL_W-1:0] {
    CT_SPECIAL = 2'b00,
    CT_LOAD    = 2'b01,
    CT_MISC    = 2'b10,
    CT_LOADUPD = 2'b11
  } ctl_e;

  typedef struct packed {
    logic [N_CH-1:0] ld_sel;
    logic            ld_all;
    logic            xfer_all;
    logic            sd_req;
    logic            upo_clr;
    logic            upo_set;
    logic            mode_clr;
    logic            mode_set;
  } op_t;
endpackage

// File: rtl/dacreg_rst_sync.sv
module dacreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/dacreg_decode.sv
module dacreg_decode
  import dacreg_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int WORD_W = ADDR_W + CTRL_W + DATA_W
) (
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  output op_t               op,
  output logic [DATA_W-1:0] data
);
  logic [ADDR_W-1:0] addr;
  ctl_e              ctl;

  assign addr = cmd_word[WORD_W-1 -: ADDR_W];
  assign ctl  = ctl_e'(cmd_word[DATA_W +: CTRL_W]);
  assign data = cmd_word[DATA_W-1:0];

  always_comb begin
    op = '0;
    if (cmd_valid) begin
      unique case (ctl)
        CT_LOAD: begin
          op.ld_sel = N_CH'(1) << addr;
        end
        CT_LOADUPD: begin
          op.ld_sel   = N_CH'(1) << addr;
          op.xfer_all = 1'b1;
        end
        CT_SPECIAL: begin
          unique case (addr)
            2'd0: ;
            2'd1: op.xfer_all = 1'b1;
            2'd2: op.ld_all   = 1'b1;
            2'd3: op.sd_req   = 1'b1;
            default: ;
          endcase
        end
        CT_MISC: begin
          unique case (addr)
            2'd0: op.upo_clr = 1'b1;
            2'd1: op.upo_set = 1'b1;
            2'd2: begin op.mode_clr = 1'b1; op.xfer_all = 1'b1; end
            2'd3: begin op.mode_set = 1'b1; op.xfer_all = 1'b1; end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dacreg_chan_bank.sv
module dacreg_chan_bank
  import dacreg_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_n,
  input  op_t                      op,
  input  logic [DATA_W-1:0]        data,
  output logic [N_CH*DATA_W-1:0]   codes
);
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [DATA_W-1:0] stage_q, stage_d;
    logic [DATA_W-1:0] live_q,  live_d;
    logic              stage_en, live_en;

    always_comb begin
      stage_en = !clr_n || op.ld_all || op.ld_sel[ch];
      live_en  = !clr_n || op.ld_all || op.xfer_all;
      if (!clr_n)                          stage_d = '0;
      else if (op.ld_all || op.ld_sel[ch]) stage_d = data;
      else                                 stage_d = stage_q;
      if (!clr_n)         live_d = '0;
      else if (op.ld_all) live_d = data;
      else                live_d = stage_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q <= '0;
        live_q  <= '0;
      end else begin
        if (stage_en) stage_q <= stage_d;
        if (live_en)  live_q  <= live_d;
      end
    end

    assign codes[ch*DATA_W +: DATA_W] = live_q;
  end
endmodule

// File: rtl/dacreg_ctrl.sv
module dacreg_ctrl
  import dacreg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_n,
  input  logic pdl_n,
  input  op_t  op,
  output logic upo,
  output logic dout_mode,
  output logic sd_q
);
  logic upo_q, upo_d, mode_q, mode_d, sd_d;
  logic live_wr;

  assign live_wr = op.ld_all || op.xfer_all;

  always_comb begin
    upo_d  = upo_q;
    mode_d = mode_q;
    sd_d   = sd_q;
    if (!clr_n) begin
      upo_d  = 1'b0;
      mode_d = 1'b0;
      sd_d   = 1'b0;
    end else begin
      if (op.upo_set)       upo_d = 1'b1;
      else if (op.upo_clr)  upo_d = 1'b0;
      if (op.mode_set)      mode_d = 1'b1;
      else if (op.mode_clr) mode_d = 1'b0;
      if (!pdl_n || live_wr) sd_d = 1'b0;
      else if (op.sd_req)    sd_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upo_q  <= 1'b0;
      mode_q <= 1'b0;
      sd_q   <= 1'b0;
    end else begin
      upo_q  <= upo_d;
      mode_q <= mode_d;
      sd_q   <= sd_d;
    end
  end

  assign upo       = upo_q;
  assign dout_mode = mode_q;
endmodule

// File: rtl/quad_dac_regctl.sv
module quad_dac_regctl
  import dacreg_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int WORD_W = ADDR_W + CTRL_W + DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr_n,
  input  logic                   pdl_n,
  input  logic                   cmd_valid,
  input  logic [WORD_W-1:0]      cmd_word,
  output logic [N_CH*DATA_W-1:0] dac_codes,
  output logic [N_CH-1:0]        out_en,
  output logic                   shutdown,
  output logic                   upo,
  output logic                   dout_mode
);
  logic              rst_n_s;
  op_t               op;
  logic [DATA_W-1:0] data;
  logic              sd_q;

  dacreg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s)
  );

  dacreg_decode #(.DATA_W(DATA_W)) u_dec (
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .op(op), .data(data)
  );

  dacreg_chan_bank #(.DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n_s), .clr_n(clr_n), .op(op), .data(data),
    .codes(dac_codes)
  );

  dacreg_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .clr_n(clr_n), .pdl_n(pdl_n), .op(op),
    .upo(upo), .dout_mode(dout_mode), .sd_q(sd_q)
  );

  assign shutdown = sd_q && pdl_n;
  assign out_en   = {N_CH{!shutdown}};
endmodule

// File: rtl/dacreg_chk.sv
module dacreg_chk
  import dacreg_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int WORD_W = ADDR_W + CTRL_W + DATA_W
) (
  input logic                   clk,
  input logic                   rst_n_s,
  input logic                   clr_n,
  input logic                   pdl_n,
  input logic                   cmd_valid,
  input logic [WORD_W-1:0]      cmd_word,
  input logic [N_CH*DATA_W-1:0] dac_codes,
  input logic [N_CH-1:0]        out_en,
  input logic                   shutdown,
  input logic                   upo,
  input logic                   dout_mode
);
  logic [3:0]        code;
  logic [DATA_W-1:0] data;
  logic              act;
  logic              wr_live;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] picked;

  assign code    = cmd_word[WORD_W-1 -: 4];
  assign data    = cmd_word[DATA_W-1:0];
  assign act     = cmd_valid && clr_n;
  assign wr_live = (code[1:0] == 2'b11) || code == 4'b0100 || code == 4'b1000 ||
                   code == 4'b1010 || code == 4'b1110;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) addr_q <= '0;
    else          addr_q <= code[3:2];
  end
  assign picked = dac_codes[addr_q*DATA_W +: DATA_W];

  AST_LOAD_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    act && code[1:0] == 2'b01 |=> $stable(dac_codes)); // R1
  AST_LOADUPD_CHAN: assert property (@(posedge clk) disable iff (!rst_n_s)
    act && code[1:0] == 2'b11 |=> picked == $past(data)); // R2
  AST_BCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n_s)
    act && code == 4'b1000 |=> dac_codes == {N_CH{$past(data)}}); // R4
  AST_SD_ENTER: assert property (@(posedge clk) disable iff (!rst_n_s)
    act && code == 4'b1100 && pdl_n |=> shutdown || !pdl_n); // R5
  AST_SD_ENABLES: assert property (@(posedge clk) disable iff (!rst_n_s)
    shutdown |-> out_en == '0); // R5
  AST_UPO_HIGH: assert property (@(posedge clk) disable iff (!rst_n_s)
    act && code == 4'b0110 |=> upo); // R6
  AST_MODE_ONE: assert property (@(posedge clk) disable iff (!rst_n_s)
    act && code == 4'b1110 |=> dout_mode); // R7
  AST_NOP_STABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    act && code == 4'b0000 |=> $stable(dac_codes) && $stable(upo) && $stable(dout_mode)); // R8
  AST_WAKE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n_s)
    act && wr_live |=> !shutdown); // R9
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n_s)
    !pdl_n |-> !shutdown && out_en == '1); // R10
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n_s)
    !clr_n |=> dac_codes == '0 && !upo && !dout_mode && !shutdown); // R11
endmodule

bind quad_dac_regctl dacreg_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .clr_n(clr_n), .pdl_n(pdl_n),
  .cmd_valid(cmd_valid), .cmd_word(cmd_word), .dac_codes(dac_codes),
  .out_en(out_en), .shutdown(shutdown), .upo(upo), .dout_mode(dout_mode)
);

// File: tb/tb_quad_dac_regctl.sv
`timescale 1ns/1ps
module tb_quad_dac_regctl;
  logic        clk = 1'b0;
  logic        rst_n, clr_n, pdl_n, cmd_valid;
  logic [15:0] cmd_word;
  logic [47:0] dac_codes;
  logic [3:0]  out_en;
  logic        shutdown, upo, dout_mode;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int m_stage[4];
  int m_live[4];
  int m_upo, m_mode, m_sd;

  always #2.5 clk = ~clk;

  quad_dac_regctl dut (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .pdl_n(pdl_n),
    .cmd_valid(cmd_valid), .cmd_word(cmd_word), .dac_codes(dac_codes),
    .out_en(out_en), .shutdown(shutdown), .upo(upo), .dout_mode(dout_mode)
  );

  task automatic compare(input string tag);
    int exp_sd;
    exp_sd = (m_sd != 0 && pdl_n) ? 1 : 0;
    checks++;
    for (int i = 0; i < 4; i++)
      if (dac_codes[i*12 +: 12] !== 12'(m_live[i])) begin
        fails++;
        $display("FAIL %s ch%0d code act=%h exp=%h", tag, i, dac_codes[i*12 +: 12], m_live[i]);
      end
    if (shutdown !== exp_sd[0] || out_en !== {4{!exp_sd[0]}}) begin
      fails++;
      $display("FAIL %s shutdown/out_en act=%b/%b exp=%0d/%b", tag, shutdown, out_en, exp_sd, {4{!exp_sd[0]}});
    end
    if (upo !== m_upo[0] || dout_mode !== m_mode[0]) begin
      fails++;
      $display("FAIL %s upo/mode act=%b/%b exp=%0d/%0d", tag, upo, dout_mode, m_upo, m_mode);
    end
  endtask

  // behavioural model of one clock edge
  task automatic model_edge(input bit v, input logic [15:0] w, input bit cl, input bit pd);
    int a, c, d;
    bit wr;
    a = w[15:14]; c = w[13:12]; d = w[11:0]; wr = 0;
    if (!cl) begin
      for (int i = 0; i < 4; i++) begin m_stage[i] = 0; m_live[i] = 0; end
      m_upo = 0; m_mode = 0; m_sd = 0;
      return;
    end
    if (v) begin
      if (c == 1) m_stage[a] = d;
      else if (c == 3) begin m_stage[a] = d; m_live = m_stage; wr = 1; end
      else if (c == 0) begin
        if (a == 1) begin m_live = m_stage; wr = 1; end
        else if (a == 2) begin
          for (int i = 0; i < 4; i++) begin m_stage[i] = d; m_live[i] = d; end
          wr = 1;
        end else if (a == 3 && pd) m_sd = 1;
      end else begin
        if (a == 0) m_upo = 0;
        else if (a == 1) m_upo = 1;
        else begin m_mode = (a == 3); m_live = m_stage; wr = 1; end
      end
    end
    if (wr || !pd) m_sd = 0;
  endtask

  task automatic step(input string tag, input bit v, input logic [15:0] w,
                      input bit cl = 1, input bit pd = 1);
    cmd_valid = v; cmd_word = w; clr_n = cl; pdl_n = pd;
    #1 compare(tag);
    model_edge(v, w, cl, pd);
    @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input int a, input int c, input int d);
    return {a[1:0], c[1:0], d[11:0]};
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_stage[i] = 0; m_live[i] = 0; end
    m_upo = 0; m_mode = 0; m_sd = 0;
    rst_n = 0; clr_n = 1; pdl_n = 1; cmd_valid = 0; cmd_word = '0;
    repeat (3) @(negedge clk);
    compare("R12 reset");
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare("R12 after release");

    // R1: staging loads only
    for (int i = 0; i < 4; i++) step("R1 stage load", 1, mk(i, 1, 'h111 * (i + 1)));
    step("R1 live unchanged", 0, 0);
    // R3: transfer all
    step("R3 xfer", 1, mk(1, 0, 'hABC));
    step("R3 check", 0, 0);
    // R2: load and update
    step("R2 loadupd", 1, mk(2, 3, 'h5A5));
    step("R2 check", 0, 0);
    // R4: broadcast
    step("R4 bcast", 1, mk(2, 0, 'hFFF));
    step("R4 check", 0, 0);
    step("R1 stage after bcast", 1, mk(0, 1, 'h001));
    // R6
    step("R6 upo high", 1, mk(1, 2, 0));
    step("R6 upo low", 1, mk(0, 2, 'hFFF));
    step("R6 check", 1, mk(1, 2, 0));
    // R7
    step("R7 mode1", 1, mk(3, 2, 0));
    step("R7 mode0", 1, mk(2, 2, 0));
    step("R7 mode1 again", 1, mk(3, 2, 0));
    // R8
    step("R8 nop", 1, mk(0, 0, 'hFFF));
    step("R8 check", 0, 0);
    // R5 shutdown and retention
    step("R1 stage pre-sd", 1, mk(3, 1, 'h0F0));
    step("R5 enter sd", 1, mk(3, 0, 0));
    step("R5 in sd", 0, 0);
    step("R5 nop in sd", 1, mk(0, 0, 0));
    // R9 wake by transfer
    step("R9 wake xfer", 1, mk(1, 0, 0));
    step("R9 check", 0, 0);
    // R5 lockout veto
    step("R5 veto", 1, mk(3, 0, 0), 1, 0);
    step("R5 veto check", 0, 0, 1, 0);
    step("R5 veto check hi", 0, 0);
    // R10 async wake
    step("R5 enter again", 1, mk(3, 0, 0));
    step("R5 sd", 0, 0);
    step("R10 pdl low", 0, 0, 1, 0);
    step("R10 pdl back", 0, 0);
    // R9 wake by broadcast
    step("R5 enter 3", 1, mk(3, 0, 0));
    step("R9 wake bcast", 1, mk(2, 0, 'h321));
    step("R9 wake mode", 0, 0);
    // R11 clear overrides command
    step("R6 upo high", 1, mk(1, 2, 0));
    step("R11 clear", 1, mk(2, 0, 'h777), 0, 1);
    step("R11 check", 0, 0);
    step("R11 staging zero", 1, mk(1, 0, 0));
    step("R11 staging check", 0, 0);

    for (int n = 0; n < 400; n++) begin
      logic [15:0] w;
      bit pd, cl, v;
      w  = 16'($urandom);
      v  = ($urandom % 4) != 0;
      pd = ($urandom % 8) != 0;
      cl = ($urandom % 32) != 0;
      step("RND R1..R11", v, w, cl, pd);
    end
    cmd_valid = 0; pdl_n = 1; clr_n = 1;
    #1 compare("final");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule